// File: doc/BRIEF.md
# UART Transmit Queue with Burst DMA Request

This block buffers outgoing UART bytes in a 64-entry FIFO. A DMA engine or a CPU fills it through a byte write port. The serializer drains it one byte at a time through a read port. Two configuration inputs set when a DMA transfer is requested. The trigger level is the burst length. The threshold is extra headroom that must also be free before a burst is requested.

The block drives a level DMA request that frames exactly one burst. The request rises when enough space is free, and it falls as soon as the burst's last byte has been accepted. It is evaluated only from the occupancy count, so the moment the FIFO stops being full cannot trigger an extra request on its own.

The block also accepts a clock-idle request. It answers with an acknowledge whenever the queue is empty and no burst is open. This works whatever DMA was doing earlier, and also after a clear.

Top module: `uart_txq_dma`

## Requirements
- R1: After reset, `q_empty`=1, `q_full`=0, `dma_req`=0, `ovf_sticky`=0, `idle_ack`=0 and `rd_data`=0.
- R2: Bytes leave in the order they were written. `rd_data` shows the byte in the cycle after the cycle in which `rd_en` was sampled.
- R3: `q_full` is high when 64 bytes are held. A write to a full queue is dropped and sets `ovf_sticky`, which stays high until a clear. This holds even when a read is sampled in the same cycle: acceptance is judged on the occupancy at the start of the cycle.
- R4: A read of an empty queue loads `rd_data` with 0 and moves no pointer. A write in that same cycle is still accepted.
- R5: With `dma_en` high, `cfg_burst` nonzero, no burst open and free space at least `cfg_headroom + cfg_burst`, `dma_req` rises one cycle later. When `cfg_burst` is 0, `dma_req` never rises.
- R6: `dma_req` stays high until `cfg_burst` writes have been accepted. It is low in the cycle after the edge that accepts the last of them. It may rise again only after at least one low cycle.
- R7: A full-to-not-full transition raises no request unless free space reaches `cfg_headroom + cfg_burst`. `dma_req` never rises in the cycle after the queue was full.
- R8: Dropping `dma_en` lowers `dma_req` in the next cycle and abandons the open burst.
- R9: A one-cycle `q_clear` empties the queue, clears `ovf_sticky` and lowers `dma_req`. A write in that cycle is discarded.
- R10: `idle_ack` is high in the cycle after `idle_req` is sampled high while the queue is empty and no burst is open; otherwise it is low. This holds after DMA use and after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_clear | input | 1 | Synchronous queue clear (soft reset) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to enqueue |
| rd_en | input | 1 | Read strobe from the serializer |
| rd_data | output | 8 | Byte read, valid the cycle after `rd_en` |
| cfg_headroom | input | 6 | Extra free entries required before a request |
| cfg_burst | input | 6 | Burst length in bytes; 0 disables requests |
| dma_en | input | 1 | DMA request enable |
| dma_req | output | 1 | Level DMA request for one burst |
| q_full | output | 1 | Queue holds 64 bytes |
| q_empty | output | 1 | Queue holds no byte |
| ovf_sticky | output | 1 | A write was dropped while full |
| idle_req | input | 1 | Clock-idle request |
| idle_ack | output | 1 | Clock-idle acknowledge |

## Verification
A read and a write can land in the same cycle. At the full boundary, the write is dropped and the overflow flag is raised even though the read frees a slot. At the empty boundary, the read returns zero and the write is still stored. The bench fills the queue completely and then drives both strobes together, and it does the same again on an empty queue. It judges the outcome from the returned byte, the flags and the order of the bytes drained afterwards. A second collision is the end of a burst landing on the same edge as a change of free space. This is judged by checking that the request is low for a cycle before it rises again.

// File: rtl/uart_txq_dma.sv
module uart_txq_dma #(
  parameter int DEPTH = 64,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_clear,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] cfg_headroom,
  input  logic [AW-1:0] cfg_burst,
  input  logic          dma_en,
  output logic          dma_req,
  output logic          q_full,
  output logic          q_empty,
  output logic          ovf_sticky,
  input  logic          idle_req,
  output logic          idle_ack
);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, left;
  logic [CW-1:0] count;
  logic          busy;

  assign q_full  = count == CW'(DEPTH);
  assign q_empty = count == '0;
  assign dma_req = busy;

  wire          wr_ok   = wr_en && !q_full;
  wire          rd_ok   = rd_en && !q_empty;
  wire [CW-1:0] free_sp = CW'(DEPTH) - count;
  wire [CW-1:0] need    = CW'(cfg_headroom) + CW'(cfg_burst);
  wire          arm     = dma_en && (cfg_burst != '0) && (free_sp >= need);

  always_ff @(posedge clk)
    if (!q_clear && wr_ok) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; left <= '0;
      busy <= 1'b0; ovf_sticky <= 1'b0; idle_ack <= 1'b0; rd_data <= '0;
    end else if (q_clear) begin
      wptr <= '0; rptr <= '0; count <= '0; left <= '0;
      busy <= 1'b0; ovf_sticky <= 1'b0; idle_ack <= 1'b0; rd_data <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (wr_en && q_full) ovf_sticky <= 1'b1;
      if (rd_en) rd_data <= q_empty ? '0 : mem[rptr];
      if (rd_ok) rptr <= rptr + 1'b1;
      count <= count + CW'(wr_ok) - CW'(rd_ok);
      if (!dma_en) begin
        busy <= 1'b0;
        left <= '0;
      end else if (busy) begin
        if (wr_ok) begin
          if (left == AW'(1)) busy <= 1'b0;
          left <= left - 1'b1;
        end
      end else if (arm) begin
        busy <= 1'b1;
        left <= cfg_burst;
      end
      idle_ack <= idle_req && q_empty && !busy;
    end
  end
endmodule

module uart_txq_dma_chk #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          q_clear,
  input logic          rd_en,
  input logic          dma_en,
  input logic          idle_req,
  input logic [AW-1:0] cfg_burst,
  input logic [DW-1:0] rd_data,
  input logic          dma_req,
  input logic          q_full,
  input logic          q_empty,
  input logic          ovf_sticky,
  input logic          idle_ack
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(q_full && q_empty)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf_sticky && !q_clear |=> ovf_sticky); // R3
  AST_EMPTY_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_en && q_empty && !q_clear |=> rd_data == '0); // R4
  AST_REQ_HAS_BURST: assert property (@(posedge clk) disable iff (!rst_n) $rose(dma_req) |-> $past(cfg_burst) != '0); // R5
  AST_NO_REQ_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n) q_full && !dma_req |=> !dma_req); // R7
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) dma_req |-> $past(dma_en)); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n) q_clear |=> q_empty && !dma_req && !ovf_sticky); // R9
  AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n) idle_ack |-> $past(idle_req) && $past(q_empty)); // R10
endmodule

bind uart_txq_dma uart_txq_dma_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_clear(q_clear), .rd_en(rd_en), .dma_en(dma_en),
  .idle_req(idle_req), .cfg_burst(cfg_burst), .rd_data(rd_data), .dma_req(dma_req),
  .q_full(q_full), .q_empty(q_empty), .ovf_sticky(ovf_sticky), .idle_ack(idle_ack)
);

// File: tb/uart_txq_dma_bench.sv
module uart_txq_dma_bench;
  logic clk = 1'b0, rst_n = 1'b0, q_clear = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic dma_en = 1'b0, idle_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic [5:0] cfg_headroom = '0, cfg_burst = '0;
  logic [7:0] rd_data;
  logic dma_req, q_full, q_empty, ovf_sticky, idle_ack;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  uart_txq_dma u_uart_txq_dma (
    .clk(clk), .rst_n(rst_n), .q_clear(q_clear), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .cfg_headroom(cfg_headroom), .cfg_burst(cfg_burst),
    .dma_en(dma_en), .dma_req(dma_req), .q_full(q_full), .q_empty(q_empty),
    .ovf_sticky(ovf_sticky), .idle_req(idle_req), .idle_ack(idle_ack)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic push(input logic [7:0] b); wr_en = 1; wr_data = b; step(); wr_en = 0; endtask
  task automatic pop(); rd_en = 1; step(); rd_en = 0; endtask
  task automatic clear(); q_clear = 1; step(); q_clear = 0; endtask

  task automatic t_reset();
    chk("R1 empty", q_empty, 1); chk("R1 full", q_full, 0); chk("R1 req", dma_req, 0);
    chk("R1 ovf", ovf_sticky, 0); chk("R1 ack", idle_ack, 0); chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(8'(8'h30 + i * 7));
    for (int i = 0; i < 5; i++) begin pop(); chk("R2 order", rd_data, 8'h30 + i * 7); end
    chk("R2 empty after drain", q_empty, 1);
  endtask

  task automatic t_empty_read();
    push(8'h77); pop(); chk("R4 setup", rd_data, 8'h77);
    pop(); chk("R4 empty read zero", rd_data, 0); chk("R4 still empty", q_empty, 1);
    push(8'hA5); pop(); chk("R4 pointers intact", rd_data, 8'hA5);
  endtask

  task automatic t_full_ovf();
    for (int i = 0; i < 64; i++) push(8'(i));
    chk("R3 full", q_full, 1); chk("R3 no ovf yet", ovf_sticky, 0);
    push(8'hFF); chk("R3 ovf set", ovf_sticky, 1); chk("R3 still full", q_full, 1);
    for (int i = 0; i < 64; i++) begin pop(); chk("R3 contents", rd_data, i); end
    chk("R3 drained", q_empty, 1); chk("R3 ovf sticky", ovf_sticky, 1);
    clear(); chk("R9 empty", q_empty, 1); chk("R9 ovf cleared", ovf_sticky, 0);
  endtask

  task automatic t_same_cycle();
    for (int i = 0; i < 64; i++) push(8'(100 + i));
    wr_en = 1; rd_en = 1; wr_data = 8'hEE; step(); wr_en = 0; rd_en = 0;
    chk("R3 rd+wr at full data", rd_data, 100); chk("R3 rd+wr at full ovf", ovf_sticky, 1);
    chk("R3 rd+wr at full not full", q_full, 0);
    for (int i = 1; i < 64; i++) begin pop(); chk("R3 dropped byte absent", rd_data, 100 + i); end
    chk("R3 empty", q_empty, 1);
    clear();
    wr_en = 1; rd_en = 1; wr_data = 8'h3C; step(); wr_en = 0; rd_en = 0;
    chk("R4 rd+wr at empty zero", rd_data, 0); chk("R4 write kept", q_empty, 0);
    pop(); chk("R4 write kept data", rd_data, 8'h3C);
    clear();
  endtask

  task automatic t_burst();
    cfg_headroom = 2; cfg_burst = 4; dma_en = 1; step();
    chk("R5 req rises", dma_req, 1);
    for (int i = 0; i < 3; i++) begin push(8'(i)); chk("R6 req held", dma_req, 1); end
    push(8'h03); chk("R6 req falls after burst", dma_req, 0);
    step(); chk("R6 req rises again", dma_req, 1);
    clear(); chk("R9 clear drops req", dma_req, 0);
    step(); dma_en = 0; step(); chk("R8 disable drops req", dma_req, 0);
    clear();
  endtask

  task automatic t_burst_zero();
    cfg_headroom = 0; cfg_burst = 0; dma_en = 1;
    repeat (5) step();
    chk("R5 zero burst no req", dma_req, 0);
    dma_en = 0; step();
  endtask

  task automatic t_full_fall();
    for (int i = 0; i < 64; i++) push(8'(i));
    cfg_headroom = 0; cfg_burst = 4; dma_en = 1; step();
    chk("R7 no req when full", dma_req, 0);
    pop(); chk("R7 full fell", q_full, 0); chk("R7 no req at fall", dma_req, 0);
    step(); chk("R7 no extra req", dma_req, 0);
    pop(); pop(); step(); chk("R7 free 3 no req", dma_req, 0);
    pop(); chk("R7 not yet", dma_req, 0);
    step(); chk("R7 req at free 4", dma_req, 1);
    dma_en = 0; step(); clear();
  endtask

  task automatic t_idle();
    cfg_headroom = 0; cfg_burst = 4; idle_req = 1; step();
    chk("R10 ack when empty", idle_ack, 1);
    push(8'h11); step(); chk("R10 no ack with data", idle_ack, 0);
    clear(); step(); chk("R10 ack after clear", idle_ack, 1);
    dma_en = 1; step(); step();
    chk("R10 no ack in burst", idle_ack, 0); chk("R5 req for idle test", dma_req, 1);
    dma_en = 0; step(); chk("R10 ack still low", idle_ack, 0);
    step(); chk("R10 ack after dma use", idle_ack, 1);
    idle_req = 0; step(); chk("R10 ack drops", idle_ack, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset(); t_order(); t_empty_read(); t_full_ovf(); t_same_cycle();
    t_burst(); t_burst_zero(); t_full_fall(); t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule